// File: doc/BRIEF.md
# Shared-Cause Dual Interrupt Controller

This block collects up to 32 hardware event pulses into one sticky cause register and drives two level-sensitive interrupt lines from it. A single unmask register gates every event. The events are split into two groups by bit position. Four adjacent bits, 24 through 27 by default, carry the legacy INTA..INTD events and drive the legacy-interrupt line. Every other bit drives the general event line. That line covers error reports, power-management notifications and any other event the controller raises.

Software reads both registers and clears events one by one through a small register port. Reading never clears anything. A write to the cause register clears exactly the bits written as 1. Two handlers, one per line, can therefore each retire only their own events. A line stays high, or goes high again, while any unmasked event in its group is still pending.

Top module: `shcause_irq_ctrl`

## Requirements
- R1: After reset the cause register, the unmask register, `irq_legacy` and `irq_event` all read as zero.
- R2: A one-cycle pulse on `evt_pulse[i]` sets cause bit i at that clock edge. The bit stays set until software clears it, and any number of reads of the cause register leave it set.
- R3: A write to byte offset 0x0 clears every cause bit whose write-data bit is 1. Cause bits written as 0 keep their value.
- R4: When an event pulse and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R5: Byte offset 0x4 is the unmask register. A write stores the data, and a read returns it. A 1 in bit i enables event i. Reads of offset 0x0 return the cause register.
- R6: `irq_legacy` is high exactly when some bit in positions 24..27 is both pending and unmasked. It follows a cause or unmask change one clock later.
- R7: `irq_event` is high exactly when some bit outside positions 24..27 is both pending and unmasked, with the same one-clock lag. Bits 23 and 28 belong to this group.
- R8: Clearing one event of a group leaves that group's line high while another unmasked event of the group is still pending.
- R9: A masked event still latches and stays pending, but it drives neither line. If it is unmasked later while still pending, its line goes high one clock after the unmask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 32 | One-cycle event pulses, one per cause bit |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (0x0 cause, 0x4 unmask) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_legacy | output | 1 | Level line for the legacy INTA..INTD group |
| irq_event | output | 1 | Level line for all other events |

## Verification
The bench builds the block with its default parameters: 32 event bits, the legacy group at bits 24..27, a 4-bit address and registered outputs. With these values a single unmask pattern can cover both group boundaries. Bits 23 and 28 sit on either side of the legacy group, and bits 0 and 31 sit at the ends of the vector. The bench also exercises a same-cycle set and clear on one bit, and clears inside a group while a second event of that group is still pending.

// File: rtl/shintc_pkg.sv
package shintc_pkg;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_CAUSE  = 2'd1,
      SEL_UNMASK = 2'd2
   } reg_sel_e;

   localparam int unsigned CAUSE_OFS  = 0;
   localparam int unsigned UNMASK_OFS = 4;

endpackage

// File: rtl/shintc_cause_bank.sv
module shintc_cause_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_set,
   input  logic [W-1:0] clr_req,
   output logic [W-1:0] cause_q
);

   // One sticky flop per event; a set in the same cycle overrides a clear.
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            cause_q[i] <= 1'b0;
         else if (evt_set[i])
            cause_q[i] <= 1'b1;
         else if (clr_req[i])
            cause_q[i] <= 1'b0;
      end
   end

   // R4: a pulse always leaves its bit set, even against a clear
   a_r4_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_set) |=> ((cause_q & $past(evt_set)) == $past(evt_set)));

   // R2: nothing but a clearing write removes a pending bit
   a_r2_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(cause_q) & ~$past(clr_req)) & ~cause_q) == '0));

   // R3: a cleared bit without a concurrent pulse is gone
   a_r3_clear_takes : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause_q & $past(clr_req) & ~$past(evt_set)) == '0));

endmodule

// File: rtl/shintc_unmask_reg.sv
module shintc_unmask_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] unmask_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         unmask_q <= '0;
      else if (we)
         unmask_q <= wdata;
   end

   // R5: the stored mask equals the last written value
   a_r5_unmask_store : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (unmask_q == $past(wdata)));

endmodule

// File: rtl/shintc_regif.sv
module shintc_regif
   import shintc_pkg::*;
#(
   parameter int unsigned W  = 32,
   parameter int unsigned AW = 4
) (
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   input  logic [W-1:0]  cause_q,
   input  logic [W-1:0]  unmask_q,
   output logic [W-1:0]  cause_clr,
   output logic          unmask_we,
   output logic [W-1:0]  rdata
);

   localparam logic [AW-1:0] CAUSE_A  = AW'(CAUSE_OFS);
   localparam logic [AW-1:0] UNMASK_A = AW'(UNMASK_OFS);

   reg_sel_e sel;

   always_comb begin
      if (addr == CAUSE_A)
         sel = SEL_CAUSE;
      else if (addr == UNMASK_A)
         sel = SEL_UNMASK;
      else
         sel = SEL_NONE;
   end

   always_comb begin
      cause_clr = (wr_en && sel == SEL_CAUSE) ? wdata : '0;
      unmask_we = wr_en && sel == SEL_UNMASK;
      case (sel)
         SEL_CAUSE:  rdata = cause_q;
         SEL_UNMASK: rdata = unmask_q;
         default:    rdata = '0;
      endcase
   end

   // R3/R5: one write never reaches both registers
   always_comb begin
      a_r5_one_target : assert (!(unmask_we && (|cause_clr)));
   end

endmodule

// File: rtl/shintc_irq_split.sv
module shintc_irq_split #(
   parameter int unsigned W    = 32,
   parameter int unsigned LO   = 24,
   parameter int unsigned N    = 4,
   parameter bit          PIPE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pending,
   output logic         irq_grp,
   output logic         irq_rest
);

   localparam logic [W-1:0] GRP_MASK = {{(W-N){1'b0}}, {N{1'b1}}} << LO;

   logic grp_d, rest_d;

   assign grp_d  = |(pending & GRP_MASK);
   assign rest_d = |(pending & ~GRP_MASK);

   if (PIPE) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_grp  <= 1'b0;
            irq_rest <= 1'b0;
         end else begin
            irq_grp  <= grp_d;
            irq_rest <= rest_d;
         end
      end

      // R6: legacy line tracks its group one clock later
      a_r6_grp_rise : assert property (@(posedge clk) disable iff (!rst_n)
         (|(pending & GRP_MASK)) |=> irq_grp);
      a_r9_grp_quiet : assert property (@(posedge clk) disable iff (!rst_n)
         !(|(pending & GRP_MASK)) |=> !irq_grp);
      // R7: event line tracks everything outside the group
      a_r7_rest_rise : assert property (@(posedge clk) disable iff (!rst_n)
         (|(pending & ~GRP_MASK)) |=> irq_rest);
      a_r9_rest_quiet : assert property (@(posedge clk) disable iff (!rst_n)
         !(|(pending & ~GRP_MASK)) |=> !irq_rest);
   end else begin : g_comb
      assign irq_grp  = grp_d;
      assign irq_rest = rest_d;
   end

endmodule

// File: rtl/shcause_irq_ctrl.sv
module shcause_irq_ctrl #(
   parameter int unsigned EVT_W    = 32,
   parameter int unsigned INTX_LO  = 24,
   parameter int unsigned INTX_N   = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter bit          IRQ_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_W-1:0]  evt_pulse,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [EVT_W-1:0]  reg_wdata,
   output logic [EVT_W-1:0]  reg_rdata,
   output logic              irq_legacy,
   output logic              irq_event
);

   if (INTX_N < 1 || INTX_LO + INTX_N > EVT_W) begin : g_bad_group
      $error("legacy group must lie inside the event vector");
   end
   if (INTX_N >= EVT_W) begin : g_no_rest
      $error("event group outside the legacy bits must not be empty");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("address must be wide enough for offset 0x4");
   end

   logic [EVT_W-1:0] cause_q, unmask_q, cause_clr, pending;
   logic             unmask_we;

   shintc_regif #(.W(EVT_W), .AW(ADDR_W)) regif_i (
      .wr_en     (reg_wr_en),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .cause_q   (cause_q),
      .unmask_q  (unmask_q),
      .cause_clr (cause_clr),
      .unmask_we (unmask_we),
      .rdata     (reg_rdata)
   );

   shintc_cause_bank #(.W(EVT_W)) cause_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_set (evt_pulse),
      .clr_req (cause_clr),
      .cause_q (cause_q)
   );

   shintc_unmask_reg #(.W(EVT_W)) unmask_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (unmask_we),
      .wdata    (reg_wdata),
      .unmask_q (unmask_q)
   );

   assign pending = cause_q & unmask_q;

   shintc_irq_split #(.W(EVT_W), .LO(INTX_LO), .N(INTX_N), .PIPE(IRQ_PIPE)) split_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pending  (pending),
      .irq_grp  (irq_legacy),
      .irq_rest (irq_event)
   );

endmodule

// File: tb/shcause_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module shcause_irq_ctrl_tb_top;

   localparam logic [31:0] LEG = 32'h0F00_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt_pulse = '0;
   logic        reg_wr_en = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_legacy, irq_event;

   always #5 clk = ~clk;

   shcause_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr_en(reg_wr_en),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_legacy(irq_legacy), .irq_event(irq_event)
   );

   int    cyc = 0;
   int    n_chk = 0;
   int    n_bad = 0;
   logic [31:0] cm = '0;
   logic [31:0] um = '0;

   int    q_due[$];
   logic  q_leg[$];
   logic  q_evt[$];
   string q_tag[$];

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compares both lines against the scoreboard as they come due
   always @(negedge clk) begin
      while (q_due.size() > 0 && q_due[0] == cyc) begin
         automatic int    d = q_due.pop_front();
         automatic logic  el = q_leg.pop_front();
         automatic logic  ee = q_evt.pop_front();
         automatic string t = q_tag.pop_front();
         n_chk++;
         if (irq_legacy !== el || irq_event !== ee) begin
            n_bad++;
            $display("FAIL %s cyc %0d: legacy/event act %b%b exp %b%b",
                     t, d, irq_legacy, irq_event, el, ee);
         end
      end
   end

   task automatic step(input logic [31:0] evt, input logic we, input logic [3:0] a,
                       input logic [31:0] wd, input string tag,
                       input bit chk_rd = 1'b0, input logic [31:0] exp_rd = '0);
      @(negedge clk);
      evt_pulse = evt; reg_wr_en = we; reg_addr = a; reg_wdata = wd;
      if (we && a == 4'h0) cm = cm & ~wd;
      if (we && a == 4'h4) um = wd;
      cm = cm | evt;
      q_due.push_back(cyc + 2);
      q_leg.push_back(|(cm & um & LEG));
      q_evt.push_back(|(cm & um & ~LEG));
      q_tag.push_back(tag);
      if (chk_rd) begin
         #1;
         n_chk++;
         if (reg_rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s read @%h: act %h exp %h", tag, a, reg_rdata, exp_rd);
         end
      end
   endtask

   task automatic rd(input logic [3:0] a, input string tag);
      logic [31:0] e;
      e = (a == 4'h0) ? cm : (a == 4'h4) ? um : 32'h0;
      step('0, 1'b0, a, '0, tag, 1'b1, e);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
      step('0, 1'b1, a, d, tag);
   endtask

   task automatic ev(input int b, input string tag);
      step(32'h1 << b, 1'b0, 4'h0, '0, tag);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: act hung exp done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      n_chk++;
      if (irq_legacy !== 1'b0 || irq_event !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 lines: act %b%b exp 00", irq_legacy, irq_event);
      end
      rd(4'h0, "R1");
      rd(4'h4, "R1");

      // R2/R9: masked event latches, survives reads, raises nothing
      ev(16, "R9");
      rd(4'h0, "R2");
      rd(4'h0, "R2");
      // R5/R9: unmask legacy group and bit 16; event line comes up
      wr(4'h4, 32'h0F01_0000, "R9");
      rd(4'h4, "R5");
      // R6: legacy event 24 plus masked 17
      step(32'h0102_0000, 1'b0, 4'h0, '0, "R6");
      rd(4'h0, "R2");
      // R3/R7: clear 16 only; 17 masked so event line drops
      wr(4'h0, 32'h0001_0000, "R7");
      rd(4'h0, "R3");
      // R8: second legacy event, then clear the first
      ev(25, "R8");
      wr(4'h0, 32'h0100_0000, "R8");
      rd(4'h0, "R8");
      step('0, 1'b0, 4'h0, '0, "R8");
      // R4: pulse 26 while clearing 25 and 26
      step(32'h0400_0000, 1'b1, 4'h0, 32'h0600_0000, "R4");
      rd(4'h0, "R4");
      // R9: unmask everything, masked bit 17 now raises event line
      wr(4'h4, 32'hFFFF_FFFF, "R9");
      rd(4'h0, "R9");
      // clear all, then probe group edges
      wr(4'h0, 32'hFFFF_FFFF, "R3");
      rd(4'h0, "R3");
      ev(28, "R7");
      wr(4'h0, 32'h1000_0000, "R7");
      ev(23, "R7");
      wr(4'h0, 32'h0080_0000, "R7");
      ev(27, "R6");
      wr(4'h0, 32'h0800_0000, "R6");
      ev(0, "R7");
      ev(31, "R7");
      wr(4'h0, 32'h0000_0001, "R8");
      wr(4'h0, 32'h8000_0000, "R7");
      rd(4'h0, "R3");
      repeat (3) step('0, 1'b0, 4'h0, '0, "R1");
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule